// File: doc/BRIEF.md
# Memory-Mapped Eight-Pin GPIO Bank with Interrupt Detection

This block is an eight-pin general purpose I/O bank that sits on a simple byte-wide register bus. Each pin can be driven as an output or sampled as an input. Software reaches the pin data through a data window in which the address itself carries a per-pin mask. This lets a single access touch any chosen subset of pins without a read-modify-write sequence.

Every pin has its own interrupt detector. The detector runs on the synchronised pad value. It can be level-sensitive with either polarity, or edge-sensitive on the rising edge, the falling edge or both edges. Detected edges are held until software acknowledges them. Level conditions follow the pad. A per-pin enable gates each raw event into a pending view, and the OR of the pending bits drives a single interrupt line to the system.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero. So pin_oe_o, pin_o and irq_o are 0, and every register reads 0.
- R2: The direction register sits at byte offset 0x400. Writing it updates pin_oe_o on the next cycle, where bit n = 1 means pin n is driven. A read returns the value last written.
- R3: A write with addr_i[11:10] = 0 is a data write. It updates output bit n only where addr_i[n+2] is 1; the other output bits keep their value.
- R4: A read with addr_i[11:10] = 0 returns bit n only where addr_i[n+2] is 1, and returns 0 for the other bits. A driven pin reads back its output value. An undriven pin reads the pad after two synchronising flops.
- R5: With bit n of the level-select register (0x404) at 0 and bit n of the dual-edge register (0x408) at 0, bit n of the polarity register (0x40C) picks the edge. A value of 1 picks a rising edge and 0 picks a falling edge. The detected edge sets raw status bit n (0x414), and the bit stays set until it is acknowledged.
- R6: In edge mode, dual-edge bit n = 1 makes both edges of pin n set raw bit n, whatever the polarity bit holds.
- R7: With level-select bit n = 1, raw bit n equals the synchronised pad when polarity bit n = 1, and its inverse when polarity bit n = 0. It is never latched, and an acknowledge has no effect on it while the level persists.
- R8: Writing the acknowledge register (0x41C) clears each latched edge bit whose data bit is 1. Bits written as 0 are left unchanged.
- R9: The pending register (0x418) reads the raw status ANDed with the enable register (0x410). irq_o is the OR of the pending bits. Raw status is recorded whatever the enables hold.
- R10: Writes to the raw and pending registers have no effect, and the acknowledge register reads 0.
- R11: When an acknowledge of a bit and a new edge on that pin fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe for this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as a read strobe |
| pin_i | input | 8 | Pad input values, asynchronous |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to produce from the ports is R11: an acknowledge that lands in the same clock cycle in which a new edge reaches the latch. Reaching it means counting the two synchronising flops and the edge-history flop from the moment the pad toggles. The bench raises the pad on a falling clock edge. It then lets two rising edges pass, and holds the acknowledge write across exactly the third rising edge, which is the edge at which the latch captures the event. A design where the clear takes priority would read back 0 there. The level-mode test uses a similar approach: it acknowledges while the level is still present, to show that the clear does not stick.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word index within the control page (byte offset 0x400 + 4*index)
  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_LVL  = 3'd1,
    SEL_ANY  = 3'd2,
    SEL_POL  = 3'd3,
    SEL_EN   = 3'd4,
    SEL_RAW  = 3'd5,
    SEL_PEND = 3'd6,
    SEL_ACK  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] lvl_mode_i,
  input  logic [W-1:0] any_edge_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q, edge_q, evt, lvl_hit, latch_set;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise       = sync_i[i] & ~prev_q[i];
    assign fall       = ~sync_i[i] & prev_q[i];
    assign evt[i]     = any_edge_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign lvl_hit[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];
    assign raw_o[i]   = lvl_mode_i[i] ? lvl_hit[i] : edge_q[i];
  end

  assign latch_set = evt & ~lvl_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= sync_i;
      edge_q <= (edge_q & ~clr_i) | latch_set;  // new edge beats clear
    end
  end

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (edge_q & $past(clr_i & ~latch_set)) == '0);

  a_r11_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (edge_q & $past(latch_set)) == $past(latch_set));

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (edge_q & $past(edge_q & ~clr_i)) == $past(edge_q & ~clr_i));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int AW   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] pad_i,
  input  logic [NPIN-1:0] raw_i,
  output logic [NPIN-1:0] dir_o,
  output logic [NPIN-1:0] out_o,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] any_o,
  output logic [NPIN-1:0] pol_o,
  output logic [NPIN-1:0] en_o,
  output logic [NPIN-1:0] clr_o
);
  localparam int MSB = NPIN + 1;      // top mask bit
  localparam int RB  = NPIN + 2;      // lowest region bit
  localparam int RW  = AW - RB;

  logic [NPIN-1:0] mask, dir_q, out_q, lvl_q, any_q, pol_q, en_q;
  logic in_data, in_regs, wr_data;
  reg_sel_e rsel;

  assign mask    = addr_i[MSB:2];
  assign in_data = addr_i[AW-1:RB] == RW'(0);
  assign in_regs = (addr_i[AW-1:RB] == RW'(1)) && (addr_i[MSB:5] == '0);
  assign rsel    = reg_sel_e'(addr_i[4:2]);
  assign wr_data = sel_i & wr_i & in_data;

  function automatic logic wr_hit(input reg_sel_e s);
    return sel_i && wr_i && in_regs && (rsel == s);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0; out_q <= '0; lvl_q <= '0;
      any_q <= '0; pol_q <= '0; en_q  <= '0;
    end else begin
      if (wr_data)         out_q <= (out_q & ~mask) | (wdata_i & mask);
      if (wr_hit(SEL_DIR)) dir_q <= wdata_i;
      if (wr_hit(SEL_LVL)) lvl_q <= wdata_i;
      if (wr_hit(SEL_ANY)) any_q <= wdata_i;
      if (wr_hit(SEL_POL)) pol_q <= wdata_i;
      if (wr_hit(SEL_EN))  en_q  <= wdata_i;
    end
  end

  assign clr_o = wr_hit(SEL_ACK) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if (in_data) rdata_o = ((dir_q & out_q) | (~dir_q & pad_i)) & mask;
      else if (in_regs) begin
        case (rsel)
          SEL_DIR:  rdata_o = dir_q;
          SEL_LVL:  rdata_o = lvl_q;
          SEL_ANY:  rdata_o = any_q;
          SEL_POL:  rdata_o = pol_q;
          SEL_EN:   rdata_o = en_q;
          SEL_RAW:  rdata_o = raw_i;
          SEL_PEND: rdata_o = raw_i & en_q;
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign lvl_o = lvl_q;
  assign any_o = any_q;
  assign pol_o = pol_q;
  assign en_o  = en_q;

  a_r3_masked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask)));

  a_r2_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit(SEL_DIR) |=> dir_q == $past(wdata_i));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN = 8,
  parameter int AW   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe_o,
  output logic            irq_o
);
  logic [NPIN-1:0] pad_s, raw, lvl, any, pol, en, clr;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i, .rst_ni, .async_i(pin_i), .sync_o(pad_s)
  );

  gpio_detect #(.W(NPIN)) u_detect (
    .clk_i, .rst_ni, .sync_i(pad_s), .lvl_mode_i(lvl), .any_edge_i(any),
    .pol_i(pol), .clr_i(clr), .raw_o(raw)
  );

  gpio_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .pad_i(pad_s), .raw_i(raw), .dir_o(pin_oe_o), .out_o(pin_o),
    .lvl_o(lvl), .any_o(any), .pol_o(pol), .en_o(en), .clr_o(clr)
  );

  assign irq_o = |(raw & en);

  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0) && (raw != '0));

  a_r1_quiet_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_oe_o == '0) && !irq_o);
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_ALL = 12'h3FC, A_DIR = 12'h400, A_LVL = 12'h404,
    A_ANY = 12'h408, A_POL = 12'h40C, A_EN = 12'h410, A_RAW = 12'h414,
    A_PEND = 12'h418, A_ACK = 12'h41C;

  logic clk = 0, rst_n = 0, sel = 0, wr = 0, irq;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pins = '0, pout, poe;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanup();
    logic [7:0] d;
    pins = '0;
    bus_wr(A_LVL, 0); bus_wr(A_ANY, 0); bus_wr(A_POL, 0);
    bus_wr(A_EN, 0); bus_wr(A_DIR, 0);
    settle();
    bus_wr(A_ACK, 8'hFF);
    bus_rd(A_RAW, d);
    check("cleanup raw", d, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pin_oe", poe, 8'h00);
    check("R1 pin_o", pout, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    bus_rd(A_DIR, d); check("R1 dir", d, 8'h00);
    bus_rd(A_RAW, d); check("R1 raw", d, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    bus_wr(A_DIR, 8'hA5);
    check("R2 pin_oe", poe, 8'hA5);
    bus_rd(A_DIR, d); check("R2 readback", d, 8'hA5);
    bus_wr(A_DIR, 8'h00);
    check("R2 clear", poe, 8'h00);
  endtask

  task automatic t_masked_write();
    bus_wr(12'h004 << 3, 8'hFF);
    check("R3 single pin", pout, 8'h08);
    bus_wr(A_ALL, 8'h0F);
    check("R3 full mask", pout, 8'h0F);
    bus_wr(12'h0C0, 8'hFF);
    check("R3 partial mask", pout, 8'h3F);
  endtask

  task automatic t_masked_read();
    logic [7:0] d;
    bus_wr(A_DIR, 8'h0F);
    pins = 8'hA0;
    settle();
    bus_rd(A_ALL, d);  check("R4 full read", d, 8'hAF);
    bus_rd(12'h204, d); check("R4 mask 81", d, 8'h81);
    bus_rd(12'h140, d); check("R4 mask 50", d, 8'h00);
    bus_wr(A_ALL, 8'h00);
    cleanup();
  endtask

  task automatic t_edge_polarity();
    logic [7:0] d;
    bus_wr(A_POL, 8'h01);
    pins = 8'h03; settle();
    bus_rd(A_RAW, d); check("R5 rising", d, 8'h01);
    pins = 8'h00; settle();
    bus_rd(A_RAW, d); check("R5 falling latched", d, 8'h03);
    bus_wr(A_ACK, 8'h02);
    bus_rd(A_RAW, d); check("R8 partial ack", d, 8'h01);
    bus_wr(A_ACK, 8'h01);
    bus_rd(A_RAW, d); check("R8 ack", d, 8'h00);
    cleanup();
  endtask

  task automatic t_both_edges();
    logic [7:0] d;
    bus_wr(A_ANY, 8'h04);
    pins = 8'h04; settle();
    bus_rd(A_RAW, d); check("R6 rise", d, 8'h04);
    bus_wr(A_ACK, 8'h04);
    pins = 8'h00; settle();
    bus_rd(A_RAW, d); check("R6 fall", d, 8'h04);
    cleanup();
  endtask

  task automatic t_level();
    logic [7:0] d;
    bus_wr(A_POL, 8'h08); bus_wr(A_LVL, 8'h18);
    bus_rd(A_RAW, d); check("R7 low active", d, 8'h10);
    pins = 8'h08; settle();
    bus_rd(A_RAW, d); check("R7 high active", d, 8'h18);
    bus_wr(A_ACK, 8'h18);
    bus_rd(A_RAW, d); check("R7 ack ignored", d, 8'h18);
    pins = 8'h10; settle();
    bus_rd(A_RAW, d); check("R7 not latched", d, 8'h00);
    cleanup();
  endtask

  task automatic t_enable();
    logic [7:0] d;
    bus_wr(A_POL, 8'h03);
    pins = 8'h03; settle();
    check("R9 irq off", {7'd0, irq}, 8'h00);
    bus_wr(A_EN, 8'h01);
    bus_rd(A_PEND, d); check("R9 pending", d, 8'h01);
    check("R9 irq on", {7'd0, irq}, 8'h01);
    bus_wr(A_RAW, 8'h00); bus_wr(A_PEND, 8'h00);
    bus_rd(A_RAW, d); check("R10 raw write ignored", d, 8'h03);
    bus_rd(A_ACK, d); check("R10 ack reads zero", d, 8'h00);
    bus_wr(A_EN, 8'h02); bus_wr(A_ACK, 8'h02);
    check("R9 irq after ack", {7'd0, irq}, 8'h00);
    bus_rd(A_RAW, d); check("R9 raw kept", d, 8'h01);
    cleanup();
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    bus_wr(A_POL, 8'h20);
    @(negedge clk); pins = 8'h20;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    sel = 1; wr = 1; addr = A_ACK; wdata = 8'h20;
    @(posedge clk); @(negedge clk);
    sel = 0; wr = 0;
    bus_rd(A_RAW, d); check("R11 edge wins", d, 8'h20);
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_direction();
    t_masked_write();
    t_masked_read();
    t_edge_polarity();
    t_both_edges();
    t_level();
    t_enable();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule